// File: doc/BRIEF.md
# Window or Timeout Watchdog Supervisor

This block watches a host processor that must refresh it at regular intervals. Time is counted in ticks of an external millisecond strobe. Each supervision period is one of four lengths, chosen by a 2-bit code. A mode bit selects one of two behaviours. In window mode the first half of every period is closed and only the second half accepts a refresh. In timeout mode a refresh is accepted at any point in the period. The refresh strobe comes from the serial interface logic each time the timing register is addressed. A configuration write loads a new mode and period code.

The block raises a reset in two cases: a refresh arrives while the window is closed, or a period runs out with no refresh. It then gives a one-cycle reset request and holds its active-low reset output for a fixed number of ticks. While that reset is held the period counter does not move. An enable from the mode controller keeps the block idle outside the modes in which supervision applies.

The control is a four-state machine. WD_IDLE means supervision is off. WD_CLOSED is the first half of a window-mode period. WD_OPEN is the part of the period that accepts a refresh; in timeout mode this is the whole period. WD_HOLD is the reset stretch. The transitions are as follows:
- Enable rises: WD_IDLE to the restart state. The restart state is WD_CLOSED in window mode and WD_OPEN in timeout mode.
- Enable falls: WD_CLOSED or WD_OPEN to WD_IDLE.
- Configuration write: WD_CLOSED or WD_OPEN back to the restart state.
- The tick that finishes the closed half: WD_CLOSED to WD_OPEN.
- Accepted refresh: WD_OPEN back to the restart state.
- Early-refresh fault: WD_CLOSED to WD_HOLD.
- Period expiry: WD_OPEN to WD_HOLD.
- Stretch finished: WD_HOLD to the restart state if the block is enabled, otherwise to WD_IDLE.

Top module: `wdog_sup`

## Requirements
- R1: After rst_n is released the block is idle with rst_out_n high and rst_req low, the mode is window (mode bit 1), and the period code is 11.
- R2: The period codes 00, 01, 10 and 11 select 5, 45, 100 and 350 ticks. If that many ticks pass after a restart with no refresh, the block faults. With one fewer tick it does not fault.
- R3: In window mode, for a period of P ticks, the first floor(P/2) ticks after a restart form the closed window and the remaining ticks form the open window.
- R4: A refresh while the window is closed is a fault.
- R5: A refresh in the open window is accepted. In timeout mode (mode bit 0) a refresh is accepted at any point in the period. An accepted refresh restarts the period at tick zero, in the closed window when in window mode.
- R6: A configuration write loads the mode bit and the period code and restarts the period at tick zero. A refresh in the same cycle as a configuration write causes no fault.
- R7: While the enable is low the block neither counts nor faults, and rst_out_n stays high. When the enable rises, the period starts at tick zero.
- R8: A fault makes rst_req high for exactly one clock. That clock follows the edge that sampled the fault, and it is the same clock in which rst_out_n goes low.
- R9: rst_out_n stays low until RST_TICKS ticks (default 1) have been seen after the fault. During that time refreshes are ignored and the period count is frozen. Afterwards the period restarts at tick zero.
- R10: When a refresh and a tick arrive in the same cycle, the refresh takes effect and that tick is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ms_tick | input | 1 | One-cycle strobe per millisecond time unit |
| wd_enable | input | 1 | Supervision allowed (from the mode controller) |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_window | input | 1 | 1 = window mode, 0 = timeout mode |
| cfg_period | input | 2 | Period code |
| refresh | input | 1 | Refresh strobe: the timing register was addressed |
| rst_req | output | 1 | One-cycle pulse on each fault |
| rst_out_n | output | 1 | Active-low reset output, held for the stretch |

## Verification
Directed sequences refresh just before and just after the half-period boundary. This separates the closed window from the open window. Separate sequences let periods run out one tick short and exactly on time, which tests each period code. Three more cases are covered: a refresh that arrives together with a tick or with a configuration write, a refresh during the reset stretch, and a long disabled stretch. These show which input has priority and whether the count is frozen or restarted. Constrained random traffic then mixes the enable, refreshes, ticks and reconfiguration. It is compared cycle by cycle with a behavioural model, which exposes any phase or count drift.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
    typedef enum logic [1:0] {
        WD_IDLE   = 2'd0,
        WD_CLOSED = 2'd1,
        WD_OPEN   = 2'd2,
        WD_HOLD   = 2'd3
    } wd_state_t;

    function automatic int unsigned max4(int unsigned a, int unsigned b,
                                         int unsigned c, int unsigned d);
        int unsigned m;
        m = a;
        if (b > m) m = b;
        if (c > m) m = c;
        if (d > m) m = d;
        return m;
    endfunction
endpackage

// File: rtl/wdog_period_sel.sv
module wdog_period_sel #(
    parameter int unsigned P0 = 5,
    parameter int unsigned P1 = 45,
    parameter int unsigned P2 = 100,
    parameter int unsigned P3 = 350,
    parameter int unsigned CW = 9
) (
    input  logic [1:0]    code,
    output logic [CW-1:0] period,
    output logic [CW-1:0] half
);
    localparam int unsigned NCODE = 4;
    localparam int unsigned PTAB [NCODE] = '{P0, P1, P2, P3};

    logic [CW-1:0] opt [NCODE];

    for (genvar g = 0; g < NCODE; g++) begin : g_opt
        assign opt[g] = CW'(PTAB[g]);
    end

    always_comb begin
        period = opt[code];
        half   = period >> 1;
    end
endmodule

// File: rtl/wdog_tick_ctr.sv
module wdog_tick_ctr #(
    parameter int unsigned CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          inc,
    input  logic [CW-1:0] period,
    input  logic [CW-1:0] half,
    output logic [CW-1:0] cnt,
    output logic          hit_half,
    output logic          hit_end
);
    logic [CW-1:0] cnt_nx;

    assign cnt_nx   = cnt + CW'(1);
    assign hit_half = (cnt_nx == half);
    assign hit_end  = (cnt_nx == period);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt_nx;
    end
endmodule

// File: rtl/wdog_hold_ctr.sv
module wdog_hold_ctr #(
    parameter int unsigned RST_TICKS = 1,
    parameter int unsigned RW = 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic done_nx
);
    logic [RW-1:0] rcnt;

    assign done_nx = ((rcnt + RW'(1)) == RW'(RST_TICKS));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   rcnt <= '0;
        else if (clr) rcnt <= '0;
        else if (inc) rcnt <= rcnt + RW'(1);
    end
endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      en,
    input  logic      tick,
    input  logic      cfg_we,
    input  logic      cfg_window,
    input  logic      win_q,
    input  logic      refresh,
    input  logic      hit_half,
    input  logic      hit_end,
    input  logic      hold_done,
    output wd_state_t state,
    output logic      cnt_clr,
    output logic      cnt_inc,
    output logic      hold_clr,
    output logic      hold_inc,
    output logic      rst_req,
    output logic      rst_out_n
);
    wd_state_t state_nx;
    wd_state_t restart_st;
    logic      fault;
    logic      req_q;

    assign restart_st = (cfg_we ? cfg_window : win_q) ? WD_CLOSED : WD_OPEN;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= WD_IDLE;
            req_q <= 1'b0;
        end else begin
            state <= state_nx;
            req_q <= fault;
        end
    end

    always_comb begin
        state_nx = state;
        cnt_clr  = 1'b0;
        cnt_inc  = 1'b0;
        hold_clr = 1'b0;
        hold_inc = 1'b0;
        fault    = 1'b0;
        unique case (state)
            WD_IDLE: begin
                cnt_clr = 1'b1;
                if (en) state_nx = restart_st;
            end
            WD_CLOSED: begin
                if (!en) begin
                    state_nx = WD_IDLE;
                    cnt_clr  = 1'b1;
                end else if (cfg_we) begin
                    state_nx = restart_st;
                    cnt_clr  = 1'b1;
                end else if (refresh) begin
                    state_nx = WD_HOLD;
                    fault    = 1'b1;
                    hold_clr = 1'b1;
                end else if (tick) begin
                    cnt_inc = 1'b1;
                    if (hit_half) state_nx = WD_OPEN;
                end
            end
            WD_OPEN: begin
                if (!en) begin
                    state_nx = WD_IDLE;
                    cnt_clr  = 1'b1;
                end else if (cfg_we || refresh) begin
                    state_nx = restart_st;
                    cnt_clr  = 1'b1;
                end else if (tick) begin
                    if (hit_end) begin
                        state_nx = WD_HOLD;
                        fault    = 1'b1;
                        hold_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
            end
            WD_HOLD: begin
                if (tick) begin
                    if (hold_done) begin
                        state_nx = en ? restart_st : WD_IDLE;
                        cnt_clr  = 1'b1;
                    end else begin
                        hold_inc = 1'b1;
                    end
                end
            end
            default: state_nx = WD_IDLE;
        endcase
    end

    always_comb begin
        rst_req   = req_q;
        rst_out_n = (state != WD_HOLD);
    end
endmodule

// File: rtl/wdog_sup.sv
module wdog_sup
    import wdog_pkg::*;
#(
    parameter int unsigned P_CODE0   = 5,
    parameter int unsigned P_CODE1   = 45,
    parameter int unsigned P_CODE2   = 100,
    parameter int unsigned P_CODE3   = 350,
    parameter int unsigned RST_TICKS = 1,
    parameter logic [1:0]  DEF_CODE  = 2'b11
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ms_tick,
    input  logic       wd_enable,
    input  logic       cfg_we,
    input  logic       cfg_window,
    input  logic [1:0] cfg_period,
    input  logic       refresh,
    output logic       rst_req,
    output logic       rst_out_n
);
    localparam int unsigned PMAX = max4(P_CODE0, P_CODE1, P_CODE2, P_CODE3);
    localparam int unsigned CW   = $clog2(PMAX + 1);
    localparam int unsigned RW   = (RST_TICKS < 2) ? 1 : $clog2(RST_TICKS + 1);

    logic          win_q;
    logic [1:0]    code_q;
    logic [CW-1:0] period;
    logic [CW-1:0] half;
    logic [CW-1:0] cnt;
    logic          hit_half;
    logic          hit_end;
    logic          hold_done;
    logic          cnt_clr;
    logic          cnt_inc;
    logic          hold_clr;
    logic          hold_inc;
    wd_state_t     state;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            win_q  <= 1'b1;
            code_q <= DEF_CODE;
        end else if (cfg_we) begin
            win_q  <= cfg_window;
            code_q <= cfg_period;
        end
    end

    wdog_period_sel #(
        .P0(P_CODE0), .P1(P_CODE1), .P2(P_CODE2), .P3(P_CODE3), .CW(CW)
    ) u_psel (
        .code   (code_q),
        .period (period),
        .half   (half)
    );

    wdog_tick_ctr #(.CW(CW)) u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (cnt_clr),
        .inc      (cnt_inc),
        .period   (period),
        .half     (half),
        .cnt      (cnt),
        .hit_half (hit_half),
        .hit_end  (hit_end)
    );

    wdog_hold_ctr #(.RST_TICKS(RST_TICKS), .RW(RW)) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (hold_clr),
        .inc     (hold_inc),
        .done_nx (hold_done)
    );

    wdog_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .en         (wd_enable),
        .tick       (ms_tick),
        .cfg_we     (cfg_we),
        .cfg_window (cfg_window),
        .win_q      (win_q),
        .refresh    (refresh),
        .hit_half   (hit_half),
        .hit_end    (hit_end),
        .hold_done  (hold_done),
        .state      (state),
        .cnt_clr    (cnt_clr),
        .cnt_inc    (cnt_inc),
        .hold_clr   (hold_clr),
        .hold_inc   (hold_inc),
        .rst_req    (rst_req),
        .rst_out_n  (rst_out_n)
    );
endmodule

// File: rtl/wdog_sup_chk.sv
module wdog_sup_chk
    import wdog_pkg::*;
#(
    parameter int unsigned CW = 9
) (
    input logic          clk,
    input logic          rst_n,
    input logic          en,
    input logic          tick,
    input logic          cfg_we,
    input logic          refresh,
    input wd_state_t     state,
    input logic [CW-1:0] cnt,
    input logic [CW-1:0] period,
    input logic          rst_req,
    input logic          rst_out_n
);
    a_r4_closed_refresh_faults: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == WD_CLOSED && refresh && !cfg_we) |=> (rst_req && !rst_out_n));

    a_r5_open_refresh_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && state == WD_OPEN && refresh && !cfg_we) |=> (!rst_req && cnt == '0));

    a_r6_cfg_write_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cfg_we && state != WD_HOLD) |=> (!rst_req && cnt == '0));

    a_r8_req_single: assert property (@(posedge clk) disable iff (!rst_n)
        rst_req |=> !rst_req);

    a_r8_req_with_reset_fall: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rst_out_n) |-> rst_req);

    a_r9_hold_count_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_HOLD) |=> (state != WD_HOLD || $stable(cnt)));

    a_r9_hold_waits_tick: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_HOLD && !tick) |=> (state == WD_HOLD));

    a_r7_idle_no_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (state == WD_IDLE) |-> (rst_out_n && cnt == '0));

    a_r2_count_below_period: assert property (@(posedge clk) disable iff (!rst_n)
        (state != WD_HOLD) |-> (cnt < period));
endmodule

bind wdog_sup wdog_sup_chk #(.CW(CW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (wd_enable),
    .tick      (ms_tick),
    .cfg_we    (cfg_we),
    .refresh   (refresh),
    .state     (state),
    .cnt       (cnt),
    .period    (period),
    .rst_req   (rst_req),
    .rst_out_n (rst_out_n)
);

// File: tb/wdog_sup_tb_top.sv
module wdog_sup_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int RST_TICKS  = 1;
    localparam int MAX_CYC    = 150000;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ms_tick = 1'b0;
    logic       wd_enable = 1'b0;
    logic       cfg_we = 1'b0;
    logic       cfg_window = 1'b0;
    logic [1:0] cfg_period = 2'b00;
    logic       refresh = 1'b0;
    logic       rst_req;
    logic       rst_out_n;

    int n_tests = 0;
    int n_fail  = 0;
    int cyc     = 0;

    // behavioural model state
    bit m_run, m_hold, m_req, m_win;
    bit [1:0] m_code;
    int m_cnt, m_rcnt;

    always #(CLK_PERIOD/2) clk = ~clk;

    wdog_sup dut_i (
        .clk(clk), .rst_n(rst_n), .ms_tick(ms_tick), .wd_enable(wd_enable),
        .cfg_we(cfg_we), .cfg_window(cfg_window), .cfg_period(cfg_period),
        .refresh(refresh), .rst_req(rst_req), .rst_out_n(rst_out_n)
    );

    function automatic int per_of(bit [1:0] c);
        case (c)
            2'b00: return 5;
            2'b01: return 45;
            2'b10: return 100;
            default: return 350;
        endcase
    endfunction

    task automatic model_reset();
        m_run = 0; m_hold = 0; m_req = 0; m_win = 1; m_code = 2'b11;
        m_cnt = 0; m_rcnt = 0;
    endtask

    task automatic model_fault();
        m_run = 0; m_hold = 1; m_rcnt = 0; m_req = 1;
    endtask

    task automatic model_next(bit en, bit tk, bit we, bit win, bit [1:0] code, bit rf);
        bit opn;
        m_req = 0;
        if (m_hold) begin
            if (we) begin m_win = win; m_code = code; end
            if (tk) begin
                if (m_rcnt + 1 == RST_TICKS) begin
                    m_hold = 0; m_run = en; m_cnt = 0;
                end else m_rcnt++;
            end
        end else if (!m_run) begin
            if (we) begin m_win = win; m_code = code; end
            if (en) begin m_run = 1; m_cnt = 0; end
        end else if (!en) begin
            if (we) begin m_win = win; m_code = code; end
            m_run = 0; m_cnt = 0;
        end else if (we) begin
            m_win = win; m_code = code; m_cnt = 0;
        end else if (rf) begin
            opn = !m_win || (m_cnt >= per_of(m_code) / 2);
            if (opn) m_cnt = 0;
            else model_fault();
        end else if (tk) begin
            if (m_cnt + 1 == per_of(m_code)) model_fault();
            else m_cnt++;
        end
    endtask

    task automatic chk(bit act, bit exp, string tag);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0b expected %0b", tag, act, exp);
        end
    endtask

    // drive one cycle (called at a negedge), compare with model at next negedge
    task automatic step(bit en, bit tk, bit we, bit win, bit [1:0] code, bit rf);
        wd_enable = en; ms_tick = tk; cfg_we = we; cfg_window = win;
        cfg_period = code; refresh = rf;
        model_next(en, tk, we, win, code, rf);
        @(negedge clk);
        chk(rst_out_n, !m_hold, "R9 model rst_out_n");
        chk(rst_req, m_req, "R8 model rst_req");
    endtask

    task automatic ticks(int n, string tag);
        for (int i = 0; i < n; i++) begin
            step(1, 1, 0, 0, 2'b00, 0);
            chk(rst_out_n, 1'b1, tag);
        end
    endtask

    task automatic tick1();
        step(1, 1, 0, 0, 2'b00, 0);
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > MAX_CYC) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected below %0d", cyc, MAX_CYC);
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        model_reset();
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk(rst_out_n, 1'b1, "R1 rst_out_n after reset");
        chk(rst_req, 1'b0, "R1 rst_req after reset");
        // R1 default code 11 = 350 ticks
        step(1, 0, 0, 0, 2'b00, 0);
        ticks(349, "R1 default period not yet expired");
        tick1();
        chk(rst_out_n, 1'b0, "R1 default period expiry at 350");
        chk(rst_req, 1'b1, "R8 request with expiry");
        tick1();
        // R4 early refresh in closed window, code 00
        step(1, 0, 1, 1, 2'b00, 0);
        tick1();
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_req, 1'b1, "R4 closed refresh request");
        chk(rst_out_n, 1'b0, "R4 closed refresh reset");
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_req, 1'b0, "R8 request single cycle");
        chk(rst_out_n, 1'b0, "R9 refresh ignored in hold");
        tick1();
        chk(rst_out_n, 1'b1, "R9 release after stretch");
        // R5 open refresh accepted, R2 restart to zero
        ticks(2, "R3 closed half no fault");
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_out_n, 1'b1, "R5 open refresh accepted");
        chk(rst_req, 1'b0, "R5 open refresh no request");
        ticks(4, "R2 code00 not yet expired");
        tick1();
        chk(rst_out_n, 1'b0, "R2 code00 expiry at 5");
        tick1();
        // R10 refresh with tick: tick not counted
        ticks(2, "R10 reach open");
        step(1, 1, 0, 0, 2'b00, 1);
        chk(rst_out_n, 1'b1, "R10 refresh with tick accepted");
        tick1();
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_req, 1'b1, "R10 tick not counted so still closed");
        tick1();
        // R5 timeout mode, R2 code01
        step(1, 0, 1, 0, 2'b01, 0);
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_out_n, 1'b1, "R5 timeout mode refresh at tick zero");
        ticks(44, "R2 code01 not yet expired");
        tick1();
        chk(rst_out_n, 1'b0, "R2 code01 expiry at 45");
        tick1();
        // R6 config write with refresh: no fault, restart
        step(1, 0, 1, 1, 2'b00, 0);
        tick1();
        step(1, 0, 1, 1, 2'b00, 1);
        chk(rst_out_n, 1'b1, "R6 write with refresh no fault");
        chk(rst_req, 1'b0, "R6 write with refresh no request");
        ticks(4, "R6 restart from zero");
        tick1();
        chk(rst_out_n, 1'b0, "R6 expiry 5 ticks after write");
        tick1();
        // R7 disabled
        for (int i = 0; i < 400; i++) begin
            step(0, 1, 0, 0, 2'b00, (i % 7) == 3);
            chk(rst_out_n, 1'b1, "R7 disabled no reset");
        end
        step(1, 0, 0, 0, 2'b00, 0);
        ticks(4, "R7 enable restarts at zero");
        tick1();
        chk(rst_out_n, 1'b0, "R7 expiry 5 ticks after enable");
        tick1();
        // R3 half boundary, code10
        step(1, 0, 1, 1, 2'b10, 0);
        ticks(50, "R3 code10 first half");
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_out_n, 1'b1, "R3 refresh at tick 50 open");
        ticks(49, "R3 code10 closed");
        step(1, 0, 0, 0, 2'b00, 1);
        chk(rst_req, 1'b1, "R3 refresh at tick 49 closed");
        tick1();
        // random traffic against the model
        for (int i = 0; i < 20000; i++) begin
            bit en, tk, we, win, rf;
            bit [1:0] code;
            en   = ($urandom_range(99) < 97);
            tk   = ($urandom_range(99) < 60);
            we   = ($urandom_range(999) < 4);
            win  = $urandom_range(1);
            code = 2'($urandom_range(3));
            rf   = ($urandom_range(99) < 2);
            step(en, tk, we, win, code, rf);
        end
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule